// File: doc/BRIEF.md
# Shared Bus Hub with Arbitration and Header Filtering

This block joins a fixed number of devices to one common data path. Any device may raise a request line. A fixed-priority arbiter gives the path to one requester at a time. That owner keeps the path until it marks its final word with a done flag, or until it drops its request. The owner's word, valid flag and first-word flag are steered onto the shared bus. Devices that do not own the bus are ignored.

Every transfer opens with a header word that names where the message goes. Each receiver decodes each header and records whether it was selected. It then latches the payload words that follow, and keeps doing so until the word that carries done. The header can name one receiver directly. The all-ones header reaches every receiver. A header with its top bit set picks an entry from a small group table, and that entry holds a bitmask of member receivers. A configuration port writes the group table. Any number of receivers may take the same word in the same cycle.

Top module: `sbus_hub`

## Requirements
- R1: While reset is held, and until the first grant after reset, `dev_gnt`, `bus_valid`, `bus_data` and `rx_valid` are all zero.
- R2: When no device holds a grant and at least one request is high, the grant register takes a one-hot value on the next clock edge. The set bit is the lowest-numbered device whose request is high.
- R3: While the owner keeps its request high and has not sent a valid word with done set, its grant is unchanged. This holds even when a lower-numbered device requests.
- R4: The grant goes to zero on the edge after the owner presents a valid word with `dev_tx_done` set, or on the edge after the owner drops its request. A new grant can appear one edge later at the earliest.
- R5: At most one bit of `dev_gnt` is ever set.
- R6: The owner's valid, first-word and data inputs appear on `bus_valid`, `bus_first` and `bus_data` in the same cycle. Non-owners' transmit inputs have no effect on the bus.
- R7: With no owner, `bus_valid`, `bus_first` and `bus_data` are zero.
- R8: A header word (valid and first both set) whose top bit is clear selects receiver k only when its value equals k. Values of NDEV or more select no receiver.
- R9: The all-ones header selects every receiver, including the sender.
- R10: A header whose top bit is set, and which is not all ones, selects the receivers set in group-table entry `header[GW-1:0]`. Bit k of the entry stands for receiver k. The other header bits are ignored.
- R11: When a selected receiver sees a valid non-first word on the bus in cycle t, `rx_valid[k]` is high in cycle t+1 and `rx_data` slice k holds that word. Header words are never delivered.
- R12: A pulse on `cfg_wr` writes `cfg_mask` into group entry `cfg_grp`, and later headers use the new value. After reset every entry is zero.
- R13: A receiver's selection ends after the valid word that carries done. Payload words that arrive before the next header are not delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dev_req | input | NDEV | Per-device bus request |
| dev_tx_data | input | NDEV*DW | Per-device word, device k in slice k |
| dev_tx_valid | input | NDEV | Per-device word valid |
| dev_tx_first | input | NDEV | Marks the header word |
| dev_tx_done | input | NDEV | Marks the final word of a transfer |
| dev_gnt | output | NDEV | One-hot grant |
| bus_valid | output | 1 | Shared bus valid |
| bus_first | output | 1 | Shared bus header flag |
| bus_data | output | DW | Shared bus word |
| cfg_wr | input | 1 | Group table write strobe |
| cfg_grp | input | GW | Group entry to write |
| cfg_mask | input | NDEV | Receiver bitmask to store |
| rx_valid | output | NDEV | Per-receiver delivered-word strobe |
| rx_data | output | NDEV*DW | Per-receiver latched word |

## Verification
The properties assume that a device raises its transmit flags only while it holds a grant and its request is high. They also assume that each transfer begins with exactly one first-flagged word. The stimulus keeps to these rules except in two places. In the first, a non-owner drives junk, and this tests that the mux ignores it. In the second, an owner sends payload without a header, and this tests that stale selection is cleared. The scoreboard predicts the delivered words from a bench-side copy of the group table and the header rules. It compares each delivery mask and data value in the cycle it appears.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  typedef enum logic [1:0] {
    HDR_UNICAST   = 2'd0,
    HDR_BROADCAST = 2'd1,
    HDR_GROUP     = 2'd2
  } hdr_kind_e;
endpackage

// File: rtl/sbus_arbiter.sv
module sbus_arbiter #(
  parameter int NDEV = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDEV-1:0] req,
  input  logic [NDEV-1:0] tx_valid,
  input  logic [NDEV-1:0] tx_done,
  output logic [NDEV-1:0] gnt
);
  logic [NDEV-1:0] gnt_q, gnt_d;
  logic            owned, owner_holds, owner_ends;

  assign owned       = |gnt_q;
  assign owner_holds = |(gnt_q & req);
  assign owner_ends  = |(gnt_q & tx_valid & tx_done);

  always_comb begin
    gnt_d = '0;
    if (owned) begin
      if (owner_holds && !owner_ends) gnt_d = gnt_q;
    end else begin
      for (int i = NDEV - 1; i >= 0; i--) begin
        if (req[i]) begin
          gnt_d    = '0;
          gnt_d[i] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gnt_q <= '0;
    else        gnt_q <= gnt_d;
  end

  assign gnt = gnt_q;
endmodule

// File: rtl/sbus_mux.sv
module sbus_mux #(
  parameter int NDEV = 4,
  parameter int DW   = 8
) (
  input  logic [NDEV-1:0]    gnt,
  input  logic [NDEV*DW-1:0] tx_data,
  input  logic [NDEV-1:0]    tx_valid,
  input  logic [NDEV-1:0]    tx_first,
  input  logic [NDEV-1:0]    tx_done,
  output logic               bus_valid,
  output logic               bus_first,
  output logic               bus_done,
  output logic [DW-1:0]      bus_data
);
  logic [DW-1:0] masked [NDEV];

  for (genvar k = 0; k < NDEV; k++) begin : g_mask
    assign masked[k] = tx_data[k*DW +: DW] & {DW{gnt[k]}};
  end

  always_comb begin
    bus_data = '0;
    for (int k = 0; k < NDEV; k++) bus_data = bus_data | masked[k];
  end

  assign bus_valid = |(gnt & tx_valid);
  assign bus_first = |(gnt & tx_valid & tx_first);
  assign bus_done  = |(gnt & tx_valid & tx_done);
endmodule

// File: rtl/sbus_group_table.sv
module sbus_group_table #(
  parameter int NDEV = 4,
  parameter int NGRP = 4,
  localparam int GW  = $clog2(NGRP)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [GW-1:0]        idx,
  input  logic [NDEV-1:0]      mask,
  output logic [NGRP*NDEV-1:0] table_flat
);
  for (genvar g = 0; g < NGRP; g++) begin : g_entry
    logic [NDEV-1:0] ent_q;
    logic            ent_en;
    assign ent_en = wr && (idx == GW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= '0;
      else if (ent_en) ent_q <= mask;
    end
    assign table_flat[g*NDEV +: NDEV] = ent_q;
  end
endmodule

// File: rtl/sbus_rx_filter.sv
module sbus_rx_filter
  import sbus_pkg::*;
#(
  parameter int NDEV = 4,
  parameter int DW   = 8,
  parameter int NGRP = 4,
  parameter int IDX  = 0,
  localparam int GW  = $clog2(NGRP)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_first,
  input  logic                 bus_done,
  input  logic [DW-1:0]        bus_data,
  input  logic [NGRP*NDEV-1:0] grp_table,
  output logic                 rx_valid,
  output logic [DW-1:0]        rx_data
);
  hdr_kind_e     kind;
  logic          hit;
  logic          sel_q, sel_d;
  logic          take;
  logic          rxv_q;
  logic [DW-1:0] rxd_q;
  logic [GW-1:0] gidx;

  assign gidx = bus_data[GW-1:0];

  always_comb begin
    if (bus_data == {DW{1'b1}})  kind = HDR_BROADCAST;
    else if (bus_data[DW-1])     kind = HDR_GROUP;
    else                         kind = HDR_UNICAST;
  end

  always_comb begin
    case (kind)
      HDR_BROADCAST: hit = 1'b1;
      HDR_GROUP:     hit = grp_table[int'(gidx)*NDEV + IDX];
      default:       hit = (bus_data == DW'(IDX));
    endcase
  end

  always_comb begin
    sel_d = sel_q;
    if (bus_valid && bus_done)       sel_d = 1'b0;
    else if (bus_valid && bus_first) sel_d = hit;
  end

  assign take = bus_valid && !bus_first && sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      rxv_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      rxv_q <= take;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rxd_q <= '0;
    else if (take) rxd_q <= bus_data;
  end

  assign rx_valid = rxv_q;
  assign rx_data  = rxd_q;
endmodule

// File: rtl/sbus_hub.sv
module sbus_hub #(
  parameter int NDEV = 4,
  parameter int DW   = 8,
  parameter int NGRP = 4,
  localparam int GW  = $clog2(NGRP)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NDEV-1:0]    dev_req,
  input  logic [NDEV*DW-1:0] dev_tx_data,
  input  logic [NDEV-1:0]    dev_tx_valid,
  input  logic [NDEV-1:0]    dev_tx_first,
  input  logic [NDEV-1:0]    dev_tx_done,
  output logic [NDEV-1:0]    dev_gnt,
  output logic               bus_valid,
  output logic               bus_first,
  output logic [DW-1:0]      bus_data,
  input  logic               cfg_wr,
  input  logic [GW-1:0]      cfg_grp,
  input  logic [NDEV-1:0]    cfg_mask,
  output logic [NDEV-1:0]    rx_valid,
  output logic [NDEV*DW-1:0] rx_data
);
  logic [1:0]           rst_pipe_q;
  logic                 rst_int_n;
  logic                 bus_done;
  logic [NGRP*NDEV-1:0] grp_table;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  sbus_arbiter #(.NDEV(NDEV)) u_arb (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .req      (dev_req),
    .tx_valid (dev_tx_valid),
    .tx_done  (dev_tx_done),
    .gnt      (dev_gnt)
  );

  sbus_mux #(.NDEV(NDEV), .DW(DW)) u_mux (
    .gnt       (dev_gnt),
    .tx_data   (dev_tx_data),
    .tx_valid  (dev_tx_valid),
    .tx_first  (dev_tx_first),
    .tx_done   (dev_tx_done),
    .bus_valid (bus_valid),
    .bus_first (bus_first),
    .bus_done  (bus_done),
    .bus_data  (bus_data)
  );

  sbus_group_table #(.NDEV(NDEV), .NGRP(NGRP)) u_grp (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr         (cfg_wr),
    .idx        (cfg_grp),
    .mask       (cfg_mask),
    .table_flat (grp_table)
  );

  for (genvar k = 0; k < NDEV; k++) begin : g_rx
    sbus_rx_filter #(.NDEV(NDEV), .DW(DW), .NGRP(NGRP), .IDX(k)) u_flt (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .bus_valid (bus_valid),
      .bus_first (bus_first),
      .bus_done  (bus_done),
      .bus_data  (bus_data),
      .grp_table (grp_table),
      .rx_valid  (rx_valid[k]),
      .rx_data   (rx_data[k*DW +: DW])
    );
  end
endmodule

// File: rtl/sbus_hub_chk.sv
module sbus_hub_chk #(
  parameter int NDEV = 4,
  parameter int DW   = 8
) (
  input logic            clk,
  input logic            rst_int_n,
  input logic [NDEV-1:0] dev_req,
  input logic [NDEV-1:0] dev_tx_valid,
  input logic [NDEV-1:0] dev_tx_done,
  input logic [NDEV-1:0] dev_gnt,
  input logic            bus_valid,
  input logic            bus_first,
  input logic [DW-1:0]   bus_data,
  input logic [NDEV-1:0] rx_valid
);
  // R5
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(dev_gnt));

  // R2
  idle_grant_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (dev_gnt == '0 && dev_req != '0) |=> (dev_gnt != '0));

  // R2
  top_prio_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (dev_gnt == '0 && dev_req[0]) |=> dev_gnt[0]);

  // R3
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (dev_gnt != '0 && (dev_gnt & dev_req) != '0 && (dev_gnt & dev_tx_valid & dev_tx_done) == '0)
      |=> $stable(dev_gnt));

  // R4
  release_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((dev_gnt & dev_tx_valid & dev_tx_done) != '0) |=> (dev_gnt == '0));

  // R7
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (dev_gnt == '0) |-> (!bus_valid && !bus_first && bus_data == '0));

  // R11
  no_header_delivery_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_valid && bus_first) |=> (rx_valid == '0));

  // R11
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bus_valid |=> (rx_valid == '0));

  // R9
  broadcast_all_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_valid && bus_first && bus_data == {DW{1'b1}}) ##1 (bus_valid && !bus_first)
      |=> (rx_valid == {NDEV{1'b1}}));
endmodule

bind sbus_hub sbus_hub_chk #(.NDEV(NDEV), .DW(DW)) u_chk (
  .clk          (clk),
  .rst_int_n    (rst_int_n),
  .dev_req      (dev_req),
  .dev_tx_valid (dev_tx_valid),
  .dev_tx_done  (dev_tx_done),
  .dev_gnt      (dev_gnt),
  .bus_valid    (bus_valid),
  .bus_first    (bus_first),
  .bus_data     (bus_data),
  .rx_valid     (rx_valid)
);

// File: tb/sbus_hub_bench.sv
`timescale 1ns/1ps
module sbus_hub_bench;
  localparam int NDEV = 4;
  localparam int DW   = 8;
  localparam int NGRP = 4;
  localparam int GW   = $clog2(NGRP);

  typedef struct {
    logic [NDEV-1:0] mask;
    logic [DW-1:0]   data;
    string           tag;
  } exp_t;

  logic               clk = 1'b0;
  logic               rst_n;
  logic [NDEV-1:0]    dev_req, dev_tx_valid, dev_tx_first, dev_tx_done, dev_gnt;
  logic [DW-1:0]      txd [NDEV];
  logic [NDEV*DW-1:0] dev_tx_data;
  logic               bus_valid, bus_first;
  logic [DW-1:0]      bus_data;
  logic               cfg_wr;
  logic [GW-1:0]      cfg_grp;
  logic [NDEV-1:0]    cfg_mask;
  logic [NDEV-1:0]    rx_valid;
  logic [NDEV*DW-1:0] rx_data;

  logic [NDEV-1:0]    mdl_grp [NGRP];
  exp_t               sb_q [$];
  int                 n_chk = 0;
  int                 n_fail = 0;
  bit                 done_flag = 1'b0;

  always #2 clk = ~clk;

  for (genvar k = 0; k < NDEV; k++) begin : g_pack
    assign dev_tx_data[k*DW +: DW] = txd[k];
  end

  sbus_hub #(.NDEV(NDEV), .DW(DW), .NGRP(NGRP)) u_sbus_hub (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_tx_data(dev_tx_data),
    .dev_tx_valid(dev_tx_valid), .dev_tx_first(dev_tx_first), .dev_tx_done(dev_tx_done),
    .dev_gnt(dev_gnt), .bus_valid(bus_valid), .bus_first(bus_first), .bus_data(bus_data),
    .cfg_wr(cfg_wr), .cfg_grp(cfg_grp), .cfg_mask(cfg_mask),
    .rx_valid(rx_valid), .rx_data(rx_data)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [NDEV-1:0] dest_mask(input logic [DW-1:0] hdr);
    if (hdr == {DW{1'b1}}) return {NDEV{1'b1}};
    if (hdr[DW-1])         return mdl_grp[hdr[GW-1:0]];
    if (hdr < NDEV)        return NDEV'(1) << hdr;
    return '0;
  endfunction

  task automatic program_group(input int g, input logic [NDEV-1:0] m);
    cfg_wr = 1'b1; cfg_grp = GW'(g); cfg_mask = m;
    tick();
    cfg_wr = 1'b0;
    mdl_grp[g] = m;
  endtask

  // driver: requests, waits for grant, sends header then n payload words
  task automatic send_msg(input int dev, input logic [DW-1:0] hdr, input int n,
                          input logic [DW-1:0] base, input string tag);
    logic [NDEV-1:0] m;
    m = dest_mask(hdr);
    dev_req[dev] = 1'b1;
    while (!dev_gnt[dev]) tick();
    dev_tx_valid[dev] = 1'b1; dev_tx_first[dev] = 1'b1; txd[dev] = hdr;
    tick();
    dev_tx_first[dev] = 1'b0;
    for (int k = 0; k < n; k++) begin
      txd[dev] = base + DW'(k);
      dev_tx_done[dev] = (k == n - 1);
      if (m != '0) sb_q.push_back('{mask: m, data: base + DW'(k), tag: tag});
      tick();
    end
    dev_tx_valid[dev] = 1'b0; dev_tx_done[dev] = 1'b0; dev_req[dev] = 1'b0; txd[dev] = '0;
    tick();
    tick();
  endtask

  // monitor: every delivered word must match the scoreboard head
  always @(negedge clk) begin
    if (rst_n && rx_valid != '0) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R13/R8 unexpected delivery", 32'(rx_valid), 32'h0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(rx_valid == e.mask, {e.tag, " mask"}, 32'(rx_valid), 32'(e.mask));
        for (int k = 0; k < NDEV; k++)
          if (e.mask[k])
            check(rx_data[k*DW +: DW] == e.data, {e.tag, " R11 data"},
                  32'(rx_data[k*DW +: DW]), 32'(e.data));
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    dev_req = '0; dev_tx_valid = '0; dev_tx_first = '0; dev_tx_done = '0;
    cfg_wr = 1'b0; cfg_grp = '0; cfg_mask = '0;
    for (int k = 0; k < NDEV; k++) txd[k] = '0;
    for (int g = 0; g < NGRP; g++) mdl_grp[g] = '0;
    repeat (3) tick();
    @(negedge clk);
    check(dev_gnt == '0, "R1 gnt", 32'(dev_gnt), 0);
    check(!bus_valid && bus_data == '0, "R1 bus", 32'(bus_data), 0);
    check(rx_valid == '0, "R1 rx_valid", 32'(rx_valid), 0);
    rst_n = 1'b1;
    repeat (4) tick();

    // R2: two requests, lowest index wins
    dev_req = 4'b0110;
    tick();
    check(dev_gnt == 4'b0010, "R2 lowest wins", 32'(dev_gnt), 32'h2);
    // owner 1 sends header to receiver 2; device 3 drives junk; device 0 requests
    dev_req[0] = 1'b1;
    dev_tx_valid[1] = 1'b1; dev_tx_first[1] = 1'b1; txd[1] = 8'h02;
    dev_tx_valid[3] = 1'b1; dev_tx_first[3] = 1'b1; txd[3] = 8'hAA;
    @(negedge clk);
    check(bus_valid && bus_first && bus_data == 8'h02, "R6 owner header", 32'(bus_data), 32'h02);
    tick();
    check(dev_gnt == 4'b0010, "R3 hold vs higher prio", 32'(dev_gnt), 32'h2);
    dev_tx_first[1] = 1'b0; txd[1] = 8'h55; dev_tx_done[1] = 1'b1;
    dev_tx_first[3] = 1'b0; dev_tx_done[3] = 1'b1;
    sb_q.push_back('{mask: 4'b0100, data: 8'h55, tag: "R8 unicast 2"});
    @(negedge clk);
    check(bus_data == 8'h55 && !bus_first, "R6 non-owner ignored", 32'(bus_data), 32'h55);
    tick();
    check(dev_gnt == '0, "R4 release on done", 32'(dev_gnt), 0);
    check(!bus_valid && bus_data == '0, "R7 idle bus", 32'(bus_data), 0);
    dev_req[1] = 1'b0; dev_tx_valid = '0; dev_tx_done = '0; txd[1] = '0; txd[3] = '0;
    tick();
    check(dev_gnt == 4'b0001, "R2 regrant lowest", 32'(dev_gnt), 32'h1);
    dev_req[0] = 1'b0;
    tick();
    check(dev_gnt == '0, "R4 release on request drop", 32'(dev_gnt), 0);
    tick();
    check(dev_gnt == 4'b0100, "R2 next requester", 32'(dev_gnt), 32'h4);

    send_msg(2, 8'h03, 3, 8'h10, "R8 unicast 3");
    send_msg(0, 8'h05, 2, 8'h20, "R8 out of range");
    send_msg(3, 8'hFF, 3, 8'h30, "R9 broadcast");
    send_msg(1, 8'h81, 2, 8'h40, "R12 empty group");
    program_group(1, 4'b1010);
    send_msg(0, 8'h81, 3, 8'h50, "R10 group 1");
    send_msg(2, 8'h85, 2, 8'h60, "R10 low bits select");
    send_msg(2, 8'h80, 2, 8'h70, "R10 group 0 empty");
    program_group(1, 4'b0101);
    send_msg(3, 8'h81, 2, 8'h80, "R12 rewritten group");

    // R13: payload without a header after a finished transfer
    dev_req[1] = 1'b1;
    while (!dev_gnt[1]) tick();
    dev_tx_valid[1] = 1'b1; txd[1] = 8'h3C;
    tick();
    txd[1] = 8'h3D; dev_tx_done[1] = 1'b1;
    tick();
    dev_tx_valid = '0; dev_tx_done = '0; dev_req = '0; txd[1] = '0;
    repeat (3) tick();
    check(rx_valid == '0, "R13 no stale delivery", 32'(rx_valid), 0);
    check(sb_q.size() == 0, "R11 all words delivered", 32'(sb_q.size()), 0);

    done_flag = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule